// File: doc/BRIEF.md
# External status change interrupt latch

This block watches three printer handshake lines (fault, acknowledge and busy) and turns any change of level on them into one shared interrupt request for a CPU. Each line first passes through a synchroniser. The block then compares the synchronised levels with a stored snapshot. When any line differs from its snapshot, the block captures the new levels, sets a pending flag and freezes. From then on the status byte stays exactly as it was, whatever the lines do, until software writes the reset-status command.

The host side is a plain register write port with one address bit and a combinational status read port. Address 0 is the command register and address 1 is the control register. Bit 0 of the control register is the change-interrupt enable. It is 0 after reset, and while it is 0 changes are still latched but never signalled. An interrupt acknowledge input lets the CPU take the request down without refreshing the status. The block carries no data stream: every write is a single-cycle strobe that is always accepted, so there is no valid/ready handshake and no back-pressure.

Top module: `ext_status_latch`

## Requirements
- R1: After reset, `status_o` reads 8'h07 and `irq_o` is low. The snapshot is 3'b000, the pending flag is clear and the enable is 0.
- R2: A change in either direction on any `lines_i` bit sets the pending flag, which is `status_o[7]`. A change that is stable before clock edge k is visible just after edge k+2.
- R3: `status_o[2:0]` reads the inverse of the snapshot levels. Bit 0 belongs to fault (`lines_i[0]`), bit 1 to acknowledge (`lines_i[1]`) and bit 2 to busy (`lines_i[2]`). `status_o[6:3]` reads 0.
- R4: While the flag is pending, later changes on `lines_i` leave `status_o` unchanged.
- R5: A write to address 0 with `wr_data_i[5:3]` = 3'b010 clears the pending flag and reloads the snapshot from the current synchronised levels. `irq_o` is low after that edge.
- R6: A write to address 0 with any other `wr_data_i[5:3]` value leaves `status_o` and `irq_o` unchanged.
- R7: A write to address 1 loads the enable from `wr_data_i[0]`. While the enable is 0, changes are still latched in `status_o`, but `irq_o` stays low.
- R8: `irq_o` is high exactly when the flag is pending, the enable is 1 and no acknowledge has been taken since the flag was set. Setting the enable while the flag is pending raises `irq_o` just after that write edge.
- R9: An `int_ack_i` pulse while the flag is pending drops `irq_o` after that edge. The pending flag and the status bits stay as they were, and `irq_o` stays low until a reset-status command.
- R10: If a reset-status command and a detected change fall on the same edge, the command wins. The snapshot takes the current levels and the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | 3 | Printer lines: [0] fault, [1] acknowledge, [2] busy |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wr_addr_i | input | 1 | 0 = command register, 1 = control register |
| wr_data_i | input | 8 | Write data |
| int_ack_i | input | 1 | Interrupt acknowledge pulse |
| status_o | output | 8 | [7] pending, [2:0] inverted snapshot, others 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `lines_i` is asynchronous and may change at any time. They assume that `wr_en_i`, `wr_addr_i`, `wr_data_i` and `int_ack_i` change away from the rising edge and are free of X once reset is released. The stimulus drives every input on the falling edge and holds the lines low during reset. A phase of pseudo-random line activity is mixed with commands at every offset from a line change, so that the tie between a command and a detected change is hit.

// File: rtl/esl_pkg.sv
package esl_pkg;
  localparam logic [2:0] CMD_RESET_EXT = 3'b010;
  localparam int unsigned CMD_LSB = 3;
  localparam int unsigned CMD_MSB = 5;

  typedef enum logic {
    ADDR_CMD  = 1'b0,
    ADDR_CTRL = 1'b1
  } esl_addr_e;
endpackage

// File: rtl/esl_sync.sv
module esl_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/esl_host_regs.sv
module esl_host_regs
  import esl_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          cmd_reset_o,
  output logic          enable_o
);
  logic is_cmd, is_ctrl;
  assign is_cmd  = wr_en_i && (wr_addr_i == ADDR_CMD);
  assign is_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign cmd_reset_o = is_cmd && (wr_data_i[CMD_MSB:CMD_LSB] == CMD_RESET_EXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enable_o <= 1'b0;
    else if (is_ctrl) enable_o <= wr_data_i[0];
  end

  // R7: the enable moves only on a control write
  assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ctrl |=> $stable(enable_o));
endmodule

// File: rtl/esl_change_latch.sv
module esl_change_latch #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic             cmd_reset_i,
  input  logic             enable_i,
  input  logic             int_ack_i,
  output logic [WIDTH-1:0] snap_o,
  output logic             pending_o,
  output logic             irq_o
);
  logic acked;
  logic change;
  assign change = (level_i != snap_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_o    <= '0;
      pending_o <= 1'b0;
      acked     <= 1'b0;
    end else if (cmd_reset_i) begin
      snap_o    <= level_i;
      pending_o <= 1'b0;
      acked     <= 1'b0;
    end else begin
      if (!pending_o && change) begin
        snap_o    <= level_i;
        pending_o <= 1'b1;
      end
      if (pending_o && int_ack_i) acked <= 1'b1;
    end
  end

  assign irq_o = pending_o && enable_i && !acked;

  // R2: a change seen while idle sets the pending flag
  assert_change_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && change && !cmd_reset_i) |=> pending_o);
  // R4: a pending latch stays frozen until the command
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o && !cmd_reset_i) |=> (pending_o && $stable(snap_o)));
  // R10: the command wins over a same-edge change
  assert_cmd_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset_i |=> !pending_o);
  // R9: an acknowledge keeps the request down
  assert_ack_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack_i && pending_o && !cmd_reset_i) |=> !irq_o);
endmodule

// File: rtl/ext_status_latch.sv
module ext_status_latch
  import esl_pkg::*;
#(
  parameter int unsigned N_LINES     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DW          = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               int_ack_i,
  output logic [DW-1:0]      status_o,
  output logic               irq_o
);
  localparam int unsigned PEND_BIT = DW - 1;

  logic [N_LINES-1:0] level, snap;
  logic cmd_reset, enable, pending;

  esl_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(lines_i), .sync_o(level));

  esl_host_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cmd_reset_o(cmd_reset), .enable_o(enable));

  esl_change_latch #(.WIDTH(N_LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .level_i(level), .cmd_reset_i(cmd_reset),
    .enable_i(enable), .int_ack_i(int_ack_i), .snap_o(snap),
    .pending_o(pending), .irq_o(irq_o));

  always_comb begin
    status_o              = '0;
    status_o[N_LINES-1:0] = ~snap;
    status_o[PEND_BIT]    = pending;
  end

  // R5: the request is down after a reset-status command
  assert_cmd_clears_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !irq_o);
  // R7: with the enable off and no control write, no request follows
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !(wr_en_i && wr_addr_i == ADDR_CTRL)) |=> !irq_o);
  // R6: other command codes leave the status byte alone
  assert_other_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && wr_en_i && wr_addr_i == ADDR_CMD &&
     wr_data_i[CMD_MSB:CMD_LSB] != CMD_RESET_EXT) |=> $stable(status_o));
endmodule

// File: tb/test_ext_status_latch.sv
`timescale 1ns/100ps
module test_ext_status_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] lines = 3'b000;
  logic       wr_en = 1'b0, wr_addr = 1'b0, int_ack = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status;
  logic       irq;

  int total = 0, bad = 0, cycles = 0;
  string phase = "R1";

  ext_status_latch i_ext_status_latch (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .int_ack_i(int_ack),
    .status_o(status), .irq_o(irq));

  always #2.5 clk = ~clk;

  // behavioural reference: a queue of delayed line samples plus flags
  logic [2:0] dq[$];
  logic [2:0] m_snap = 3'b000;
  bit m_pend = 0, m_en = 0, m_acked = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      dq = '{3'b000, 3'b000};
      m_snap = 3'b000; m_pend = 0; m_en = 0; m_acked = 0;
    end else begin
      logic [2:0] cur;
      bit was_pend;
      cur = dq[0];
      was_pend = m_pend;
      if (wr_en && !wr_addr && wr_data[5:3] == 3'b010) begin
        m_pend = 0; m_acked = 0; m_snap = cur;
      end else begin
        if (!m_pend && cur != m_snap) begin m_pend = 1; m_snap = cur; end
        if (was_pend && int_ack) m_acked = 1;
      end
      if (wr_en && wr_addr) m_en = wr_data[0];
      void'(dq.pop_front());
      dq.push_back(lines);
    end
  end

  task automatic check(string req, logic [7:0] act_s, logic [7:0] exp_s,
                       logic act_i, logic exp_i);
    total++;
    if (act_s !== exp_s || act_i !== exp_i) begin
      bad++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               req, act_s, act_i, exp_s, exp_i);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      check(phase, status, {m_pend, 4'b0000, ~m_snap}, irq,
            m_pend && m_en && !m_acked);
    end
  end

  task automatic wr(logic a, logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", status, 8'h07, irq, 1'b0);

    phase = "R2"; wr(1'b1, 8'h01);
    lines = 3'b001; idle(1);
    check("R2", status, 8'h07, irq, 1'b0);   // not yet through the synchroniser
    idle(2);
    check("R3", status, 8'h86, irq, 1'b1);

    phase = "R4"; lines = 3'b011; idle(4);
    check("R4", status, 8'h86, irq, 1'b1);

    phase = "R5"; wr(1'b0, 8'h10);
    check("R5", status, 8'h04, irq, 1'b0);

    phase = "R2"; lines = 3'b010; idle(4);   // falling edge on fault
    check("R2", status, 8'h85, irq, 1'b1);

    phase = "R6";
    wr(1'b0, 8'h08); wr(1'b0, 8'h18); wr(1'b0, 8'h38); wr(1'b0, 8'h00); wr(1'b0, 8'hC7);
    check("R6", status, 8'h85, irq, 1'b1);
    wr(1'b0, 8'h10);

    phase = "R7"; wr(1'b1, 8'hFE); lines = 3'b110; idle(4);
    check("R7", status, 8'h81, irq, 1'b0);

    phase = "R8"; wr(1'b1, 8'h01);
    check("R8", status, 8'h81, irq, 1'b1);

    phase = "R9"; int_ack = 1'b1; idle(1); int_ack = 1'b0;
    check("R9", status, 8'h81, irq, 1'b0);
    lines = 3'b000; idle(4);
    check("R9", status, 8'h81, irq, 1'b0);
    wr(1'b0, 8'h10);
    check("R5", status, 8'h07, irq, 1'b0);

    phase = "R10";
    for (int off = 0; off < 5; off++) begin
      lines = ~lines;
      idle(off);
      wr(1'b0, 8'h10);
      idle(4);
      wr(1'b0, 8'h10);
    end

    phase = "R2";
    begin
      logic [7:0] lf = 8'h5A;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        lines = lf[2:0];
        int_ack = lf[6] & lf[1];
        if (lf[7:5] == 3'b101) wr(1'b0, 8'h10);
        else if (lf[7:4] == 4'b0110) wr(1'b1, {7'd0, lf[0]});
        else idle(1);
      end
      int_ack = 1'b0;
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: cycles=%0d expected completion", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule